// File: doc/BRIEF.md
# Burst-Local Interleaved Parity Codec

This block protects a memory word against a cluster of upset cells that all lie within a bounded span of adjacent columns. It keeps the data bits unchanged and appends `L` parity bits. Each check is the XOR of the data bits whose positions agree modulo `L`. The parity columns are ordered so that the check each one holds also agrees with its own column number modulo `L`. Every stored column therefore belongs to check `column mod L`. Any run of up to `L` adjacent columns touches each check at most once, and that includes runs that cover a parity column and a data bit of the same check.

The block is purely combinational and has two independent paths. The encode path turns `data_in` into `code_out`. The check path recomputes all checks from a stored word on `code_in` and reports one syndrome bit per check. A third output gives, for each stored column, the number of the check that column belongs to. A downstream corrector combines this map with column-level error flags to locate the bit to invert.

Top module: `burst_parity_codec`

## Requirements
- R1: `code_out[N-1:0]` equals `data_in`. Data bit `i` (0-based, LSB first) is stored in column `i`.
- R2: The stored word has `N+L` columns. The parity bits occupy columns `N` to `N+L-1`.
- R3: Check `q` (0 to `L-1`) is the XOR of every data bit `i` with `i mod L == q`. It is stored in the parity column `N+t` for which `(N+t) mod L == q`.
- R4: When `N` is a multiple of `L`, parity column `N+t` holds check `t`, so the checks appear in ascending order.
- R5: The check that covers the last data bit `N-1` is stored in the top column `N+L-1`.
- R6: Syndrome bit `q` is the XOR of all `code_in` columns `c` with `c mod L == q`. This makes it zero for every check when `code_in` equals an unaltered `code_out`.
- R7: Flip any burst of 1 to `L` adjacent columns of a valid word at any start column. The syndrome then has exactly one bit set per flipped column, at check `c mod L`, and no check sees two flipped columns.
- R8: `col_check` holds one field per column, `CW = $clog2(L)` bits wide. Column `c` is at bits `[c*CW +: CW]` and has the value `c mod L`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| data_in | input | N | Data word to encode |
| code_out | output | N+L | Encoded stored word: data, then placed parity |
| code_in | input | N+L | Stored word to check |
| syndrome | output | L | One failing flag per check |
| col_check | output | (N+L)*CW | Check number of every stored column |

## Verification
A misplaced parity column or a wrong residue in a check shows at once: the syndrome of an unaltered word is no longer zero, and `code_out` disagrees with a model built from the requirements for the same input. A column map that is off by one places two columns of a single check inside some burst. The exhaustive burst sweep then sees a syndrome with fewer bits set than flipped columns, or a bit set at the wrong check, in the very evaluation that applies that burst. Since nothing is stored, every fault is visible as soon as the inputs settle.

// File: rtl/burst_parity_pkg.sv
package burst_parity_pkg;

    // Width of a check-number field for a given burst span (span >= 2).
    function automatic int unsigned idx_width(input int unsigned span);
        return (span > 2) ? $clog2(span) : 1;
    endfunction

    // Check that a stored column (data or parity) belongs to.
    function automatic int unsigned check_of(input int unsigned col, input int unsigned span);
        return col % span;
    endfunction

    // Parity column offset (relative to first parity column) holding check q.
    function automatic int unsigned slot_of(input int unsigned q, input int unsigned nbits,
                                            input int unsigned span);
        return (q + span - (nbits % span)) % span;
    endfunction

endpackage

// File: rtl/burst_parity_gen.sv
module burst_parity_gen #(
    parameter int N = 9,
    parameter int L = 4
) (
    input  logic [N-1:0] data,
    output logic [L-1:0] par
);
    for (genvar q = 0; q < L; q++) begin : g_chk
        logic acc;
        always_comb begin
            acc = 1'b0;
            for (int i = q; i < N; i += L) begin
                acc = acc ^ data[i];
            end
        end
        assign par[q] = acc;
    end
endmodule

// File: rtl/burst_parity_place.sv
module burst_parity_place #(
    parameter int N = 9,
    parameter int L = 4
) (
    input  logic [L-1:0] par,
    output logic [L-1:0] pcols
);
    import burst_parity_pkg::*;
    for (genvar t = 0; t < L; t++) begin : g_slot
        localparam int unsigned Q = check_of(N + t, L);
        assign pcols[t] = par[Q];
    end
endmodule

// File: rtl/burst_parity_syndrome.sv
module burst_parity_syndrome #(
    parameter int N = 9,
    parameter int L = 4
) (
    input  logic [N+L-1:0] stored,
    output logic [L-1:0]   syn
);
    import burst_parity_pkg::*;
    logic [L-1:0] recomputed;

    burst_parity_gen #(.N(N), .L(L)) u_regen (
        .data (stored[N-1:0]),
        .par  (recomputed)
    );

    for (genvar q = 0; q < L; q++) begin : g_cmp
        localparam int unsigned T = slot_of(q, N, L);
        assign syn[q] = recomputed[q] ^ stored[N + T];
    end
endmodule

// File: rtl/burst_parity_codec.sv
module burst_parity_codec #(
    parameter int N  = 9,
    parameter int L  = 4,
    parameter int W  = N + L,
    parameter int CW = burst_parity_pkg::idx_width(L)
) (
    input  logic [N-1:0]    data_in,
    output logic [W-1:0]    code_out,
    input  logic [W-1:0]    code_in,
    output logic [L-1:0]    syndrome,
    output logic [W*CW-1:0] col_check
);
    import burst_parity_pkg::*;

    logic [L-1:0] enc_par;
    logic [L-1:0] enc_cols;

    burst_parity_gen #(.N(N), .L(L)) u_gen (
        .data (data_in),
        .par  (enc_par)
    );

    burst_parity_place #(.N(N), .L(L)) u_place (
        .par   (enc_par),
        .pcols (enc_cols)
    );

    assign code_out = {enc_cols, data_in};

    burst_parity_syndrome #(.N(N), .L(L)) u_syn (
        .stored (code_in),
        .syn    (syndrome)
    );

    for (genvar c = 0; c < W; c++) begin : g_map
        localparam int unsigned Q = check_of(c, L);
        assign col_check[c*CW +: CW] = CW'(Q);
    end
endmodule

// File: rtl/burst_parity_codec_chk.sv
module burst_parity_codec_chk #(
    parameter int N  = 9,
    parameter int L  = 4,
    parameter int W  = N + L,
    parameter int CW = burst_parity_pkg::idx_width(L)
) (
    input logic [N-1:0]    data_in,
    input logic [W-1:0]    code_out,
    input logic [W-1:0]    code_in,
    input logic [L-1:0]    syndrome,
    input logic [W*CW-1:0] col_check
);
    always_comb begin
        if (!$isunknown({data_in, code_out})) begin
            a_r1_data_kept: assert (code_out[N-1:0] == data_in)
                else $error("R1 data columns differ from data_in");
        end
        if (!$isunknown({code_in, code_out, syndrome}) && code_in == code_out) begin
            a_r6_clean_roundtrip: assert (syndrome == '0)
                else $error("R6 unaltered word gives nonzero syndrome");
        end
        if (!$isunknown({code_in, syndrome})) begin
            a_r6_total_parity: assert ((^syndrome) == (^code_in))
                else $error("R6 syndrome parity disagrees with stored word parity");
        end
        if (!$isunknown(col_check)) begin
            for (int c = 0; c < W; c++) begin
                a_r8_map_range: assert (int'(col_check[c*CW +: CW]) < L)
                    else $error("R8 column %0d maps outside check range", c);
                for (int d = 1; d < L; d++) begin
                    if (c + d < W) begin
                        a_r7_burst_distinct: assert (col_check[c*CW +: CW] != col_check[(c+d)*CW +: CW])
                            else $error("R7 columns %0d and %0d share a check", c, c + d);
                    end
                end
            end
        end
    end
endmodule

bind burst_parity_codec burst_parity_codec_chk #(.N(N), .L(L), .W(W), .CW(CW)) u_chk (
    .data_in   (data_in),
    .code_out  (code_out),
    .code_in   (code_in),
    .syndrome  (syndrome),
    .col_check (col_check)
);

// File: tb/tb_burst_parity_codec.sv
module tb_burst_parity_codec;
    localparam int N  = 9;
    localparam int L  = 4;
    localparam int W  = N + L;
    localparam int CW = 2;
    localparam int N8 = 8;
    localparam int W8 = N8 + L;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    logic [N-1:0]    data_in;
    logic [W-1:0]    code_out;
    logic [W-1:0]    code_in;
    logic [L-1:0]    syndrome;
    logic [W*CW-1:0] col_check;

    logic [N8-1:0]    d8;
    logic [W8-1:0]    c8_out;
    logic [W8-1:0]    c8_in;
    logic [L-1:0]     s8;
    logic [W8*CW-1:0] m8;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    burst_parity_codec #(.N(N), .L(L)) dut (
        .data_in(data_in), .code_out(code_out), .code_in(code_in),
        .syndrome(syndrome), .col_check(col_check)
    );

    burst_parity_codec #(.N(N8), .L(L)) dut8 (
        .data_in(d8), .code_out(c8_out), .code_in(c8_in),
        .syndrome(s8), .col_check(m8)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Model for the N=9 instance, built from R1..R3.
    function automatic logic [W-1:0] model9(input logic [N-1:0] d);
        logic [L-1:0] p;
        logic [W-1:0] w;
        p = '0;
        for (int i = 0; i < N; i++) p[i % L] ^= d[i];
        w = '0;
        w[N-1:0] = d;
        for (int t = 0; t < L; t++) w[N+t] = p[(N+t) % L];
        return w;
    endfunction

    task automatic t_idle;
        data_in = '0; code_in = '0; d8 = '0; c8_in = '0;
        #1;
        check("R1 idle code_out", 64'(code_out), 64'(0));
        check("R6 idle syndrome", 64'(syndrome), 64'(0));
        check("R6 idle syndrome N8", 64'(s8), 64'(0));
    endtask

    task automatic t_encode(input logic [N-1:0] d);
        data_in = d;
        #1;
        check("R1 data columns", 64'(code_out[N-1:0]), 64'(d));
        check("R3 encoded word", 64'(code_out), 64'(model9(d)));
        check("R5 top column holds check of last bit", 64'(code_out[W-1]), 64'(^(d & 9'h111)));
        code_in = code_out;
        #1;
        check("R6 clean syndrome", 64'(syndrome), 64'(0));
    endtask

    task automatic t_single_bits;
        for (int i = 0; i < N; i++) begin
            logic [N-1:0] d;
            d = '0; d[i] = 1'b1;
            data_in = d;
            #1;
            check("R2 R3 single bit parity columns", 64'(code_out[W-1:N]),
                  64'(model9(d) >> N));
        end
    endtask

    task automatic t_multiple;
        for (int k = 0; k < 6; k++) begin
            logic [N8-1:0] d;
            logic [L-1:0]  p;
            d = N8'(8'h5A * (k + 1) + 8'h13 * k);
            p = '0;
            for (int i = 0; i < N8; i++) p[i % L] ^= d[i];
            d8 = d;
            #1;
            check("R4 ordered parity N multiple of L", 64'(c8_out), 64'({p, d}));
            c8_in = c8_out;
            #1;
            check("R6 clean syndrome N8", 64'(s8), 64'(0));
        end
    endtask

    task automatic t_map;
        for (int c = 0; c < W; c++)
            check("R8 column map", 64'(col_check[c*CW +: CW]), 64'(c % L));
        for (int c = 0; c < W8; c++)
            check("R8 column map N8", 64'(m8[c*CW +: CW]), 64'(c % L));
    endtask

    task automatic t_bursts(input logic [N-1:0] d);
        logic [W-1:0] good;
        data_in = d;
        #1;
        good = code_out;
        for (int w = 1; w <= L; w++) begin
            for (int s = 0; s + w <= W; s++) begin
                logic [W-1:0] mask;
                logic [L-1:0] exp;
                int hits [L];
                int worst;
                mask = '0;
                exp  = '0;
                for (int q = 0; q < L; q++) hits[q] = 0;
                for (int c = s; c < s + w; c++) begin
                    mask[c] = 1'b1;
                    exp[c % L] ^= 1'b1;
                    hits[c % L]++;
                end
                worst = 0;
                for (int q = 0; q < L; q++) if (hits[q] > worst) worst = hits[q];
                code_in = good ^ mask;
                #1;
                check("R7 burst syndrome", 64'(syndrome), 64'(exp));
                check("R7 burst one flip per set bit", 64'($countones(syndrome)), 64'(w));
                check("R7 at most one flip per check", 64'(worst), 64'(1));
            end
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_idle;
        t_encode(9'h000);
        t_encode(9'h1FF);
        t_encode(9'h155);
        t_encode(9'h0AA);
        t_encode(9'h100);
        t_encode(9'h0F3);
        t_single_bits;
        t_multiple;
        t_map;
        t_bursts(9'h000);
        t_bursts(9'h1B6);
        t_bursts(9'h04D);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule